// File: doc/BRIEF.md
# Per-Card Zero Suppressor with Event Bank Buffer

This block sits at the receiving end of one serial readout chain. An event on the chain is a burst of 256 bits, 16 bits for each of 16 front-end cards. The block regroups the bits into one 16-bit word per card. In normal operation it throws away every card word that is all zeros. Each card with at least one hit becomes one 32-bit record. The record holds the card's 10-bit address and the card's 16 channel bits, with one bit per channel.

Records leave the block in two ways. They appear on a stream output as soon as they are built. They are also written into a small event buffer made of several banks, and each accepted event owns one bank. A downstream reader works on the oldest bank through a word index, then releases that bank with a pop strobe. A test mode turns suppression off so that every card word is recorded. If all banks are occupied when an event begins, the whole event is discarded and a lost-event counter advances.

Top module: `chain_suppressor`

## Requirements
- R1: Every record is laid out as bits [31:22] card address, bits [21:16] zero, and bits [15:0] card word, where bit n of the card word is channel n.
- R2: An event begins with the bit sampled while `evtStart` and `serValid` are both high. Each card then occupies 16 consecutive valid bits, and card k (k = 0..15) is the k-th such group. Inside a group the first bit lands in card word bit 15 and the last bit in bit 0. The address of card k is `chainBase + k` modulo 1024.
- R3: With `testMode` low, a card word is recorded only if it is nonzero, and records keep ascending card order.
- R4: With `testMode` high, all 16 card words are recorded, zero words included.
- R5: Each accepted event takes one bank, even when it has no records. Banks are read oldest first. `headCount` gives the number of stored records, and `rdData` at index `rdWord` is the record with that position in the event's record order.
- R6: A bank stores at most 4 records. When an event yields more, only the first 4 are stored and `headTrunc` is set for that bank, while the stream output still carries every record.
- R7: When 6 banks are occupied at the start of an event, that event produces no records, takes no bank, and increments `lostCount` by one.
- R8: A `popBank` pulse releases the oldest bank and lowers `bankUsed` by one. A pulse while no bank is occupied has no effect.
- R9: After reset, `bankUsed` is 0, `headValid` is 0, `recValid` is 0 and `lostCount` is 0.
- R10: Valid bits that arrive outside an event, meaning before any start or after the 256th bit, produce no records and change no bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| serIn | input | 1 | Serial chain data bit |
| serValid | input | 1 | serIn holds a bit this cycle |
| evtStart | input | 1 | Marks the first bit of an event |
| testMode | input | 1 | 1: record every card word |
| chainBase | input | 10 | Address of card 0 of this chain |
| popBank | input | 1 | Release the oldest bank |
| rdWord | input | 2 | Record index within the oldest bank |
| recValid | output | 1 | recData holds a new record |
| recData | output | 32 | Streamed record |
| headValid | output | 1 | At least one bank is occupied |
| headCount | output | 3 | Records stored in the oldest bank |
| headTrunc | output | 1 | Oldest bank lost records |
| rdData | output | 32 | Record rdWord of the oldest bank |
| bankUsed | output | 3 | Occupied banks |
| lostCount | output | 8 | Discarded events, wrapping |

## Verification
A bit counter that slips by one position shifts every card word and address. This shows on the first streamed record, two cycles after the sixteenth bit of the first hit card. Errors in the bank pointers or occupancy show at the end of the event as a wrong `bankUsed` or `headCount`. A read order that is off shows as wrong `rdData` on the first read after a pop. Bad full-buffer accounting shows as records streaming from an event that should have been dropped, or as `lostCount` not moving.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int ADDR_W = 10;
  localparam int WORD_W = 16;
  localparam int PAD_W  = 6;
  localparam int REC_W  = ADDR_W + PAD_W + WORD_W;

  typedef struct packed {
    logic openEvt;   // allocate a bank for a starting event
    logic dropEvt;   // starting event has no room
    logic writeRec;  // current card word becomes a record
    logic closeEvt;  // last card of accepted event done
  } ctrlStrobes_t;
endpackage

// File: rtl/cs_deser.sv
module cs_deser
  import cs_pkg::*;
#(
  parameter int CARDS = 16,
  localparam int IDX_W = $clog2(CARDS),
  localparam int BIT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serIn,
  input  logic              serValid,
  input  logic              evtStart,
  output logic              wordValid,
  output logic [WORD_W-1:0] wordData,
  output logic [IDX_W-1:0]  wordIdx,
  output logic              lastWord
);
  logic              inEvt;
  logic [WORD_W-1:0] shiftReg;
  logic [BIT_W-1:0]  bitCnt;
  logic [IDX_W-1:0]  cardCnt;
  logic [WORD_W-1:0] nextShift;

  assign nextShift = {shiftReg[WORD_W-2:0], serIn};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inEvt     <= 1'b0;
      shiftReg  <= '0;
      bitCnt    <= '0;
      cardCnt   <= '0;
      wordValid <= 1'b0;
      wordData  <= '0;
      wordIdx   <= '0;
      lastWord  <= 1'b0;
    end else begin
      wordValid <= 1'b0;
      if (serValid && evtStart) begin
        inEvt    <= 1'b1;
        shiftReg <= {{(WORD_W-1){1'b0}}, serIn};
        bitCnt   <= BIT_W'(1);
        cardCnt  <= '0;
      end else if (serValid && inEvt) begin
        shiftReg <= nextShift;
        bitCnt   <= bitCnt + 1'b1;
        if (bitCnt == BIT_W'(WORD_W - 1)) begin
          wordValid <= 1'b1;
          wordData  <= nextShift;
          wordIdx   <= cardCnt;
          lastWord  <= (cardCnt == IDX_W'(CARDS - 1));
          cardCnt   <= cardCnt + 1'b1;
          if (cardCnt == IDX_W'(CARDS - 1)) inEvt <= 1'b0;
        end
      end
    end
  end

  // R2: a word needs 16 bits, so two words never come back to back
  a_r2_word_gap: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);

  // R10: no word can appear without an open event or a start
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!inEvt && !(serValid && evtStart)) |=> !wordValid);
endmodule

// File: rtl/cs_ctrl.sv
module cs_ctrl
  import cs_pkg::*;
#(
  parameter int NBANKS = 6,
  localparam int USED_W = $clog2(NBANKS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serValid,
  input  logic              evtStart,
  input  logic              testMode,
  input  logic              wordValid,
  input  logic [WORD_W-1:0] wordData,
  input  logic              lastWord,
  input  logic [USED_W-1:0] bankUsed,
  output ctrlStrobes_t      strb
);
  logic accept;
  logic startNow;
  logic closeNow;
  logic spaceOk;

  always_comb begin
    startNow = serValid && evtStart;
    closeNow = wordValid && lastWord && accept;
    spaceOk  = (int'(bankUsed) + int'(closeNow)) < NBANKS;
    strb.openEvt  = startNow && spaceOk;
    strb.dropEvt  = startNow && !spaceOk;
    strb.closeEvt = closeNow;
    strb.writeRec = wordValid && accept && (testMode || (|wordData));
  end

  always_ff @(posedge clk) begin
    if (!rstN)         accept <= 1'b0;
    else if (startNow) accept <= spaceOk;
    else if (closeNow) accept <= 1'b0;
  end

  // R7: an event is dropped only when every bank is taken after this cycle's close
  a_r7_drop_only_full: assert property (@(posedge clk) disable iff (!rstN)
    strb.dropEvt |-> (int'(bankUsed) + int'(strb.closeEvt)) == NBANKS);

  // R3: in normal mode a zero word never becomes a record
  a_r3_zero_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && !testMode && wordData == '0) |-> !strb.writeRec);
endmodule

// File: rtl/cs_bank_store.sv
module cs_bank_store
  import cs_pkg::*;
#(
  parameter int CARDS  = 16,
  parameter int NBANKS = 6,
  parameter int DEPTH  = 4,
  parameter int LOST_W = 8,
  localparam int IDX_W  = $clog2(CARDS),
  localparam int BANK_W = $clog2(NBANKS),
  localparam int SLOT_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int USED_W = $clog2(NBANKS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [WORD_W-1:0] wordData,
  input  logic [IDX_W-1:0]  wordIdx,
  input  logic [ADDR_W-1:0] chainBase,
  input  logic              popBank,
  input  logic [SLOT_W-1:0] rdWord,
  output logic              recValid,
  output logic [REC_W-1:0]  recData,
  output logic              headValid,
  output logic [CNT_W-1:0]  headCount,
  output logic              headTrunc,
  output logic [REC_W-1:0]  rdData,
  output logic [USED_W-1:0] bankUsed,
  output logic [LOST_W-1:0] lostCount
);
  logic [BANK_W-1:0] head, tail, openSlot;
  logic [REC_W-1:0]  newRec;
  logic              popOk;

  logic [NBANKS-1:0][REC_W-1:0] bankWord;
  logic [NBANKS-1:0][CNT_W-1:0] bankCnt;
  logic [NBANKS-1:0]            bankTrunc;

  function automatic logic [BANK_W-1:0] stepBank(input logic [BANK_W-1:0] b);
    return (b == BANK_W'(NBANKS - 1)) ? '0 : b + 1'b1;
  endfunction

  assign newRec   = {chainBase + ADDR_W'(wordIdx), {PAD_W{1'b0}}, wordData};
  assign openSlot = strb.closeEvt ? stepBank(tail) : tail;
  assign popOk    = popBank && (bankUsed != '0);

  for (genvar g = 0; g < NBANKS; g++) begin : g_bank
    logic [REC_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0] cnt;
    logic             trunc;
    logic             wrHere;

    assign wrHere = strb.writeRec && (tail == BANK_W'(g))
                    && !(strb.openEvt && openSlot == BANK_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cnt   <= '0;
        trunc <= 1'b0;
      end else if (strb.openEvt && openSlot == BANK_W'(g)) begin
        cnt   <= '0;
        trunc <= 1'b0;
      end else if (wrHere) begin
        if (cnt < CNT_W'(DEPTH)) cnt <= cnt + 1'b1;
        else                     trunc <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (wrHere && cnt < CNT_W'(DEPTH)) mem[cnt[SLOT_W-1:0]] <= newRec;
    end

    assign bankWord[g]  = mem[rdWord];
    assign bankCnt[g]   = cnt;
    assign bankTrunc[g] = trunc;

    // R6: a bank never holds more than its depth
    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rstN)
      cnt <= CNT_W'(DEPTH));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      head      <= '0;
      tail      <= '0;
      bankUsed  <= '0;
      lostCount <= '0;
      recValid  <= 1'b0;
      recData   <= '0;
    end else begin
      if (strb.closeEvt) tail <= stepBank(tail);
      if (popOk)         head <= stepBank(head);
      bankUsed <= bankUsed + USED_W'(strb.closeEvt) - USED_W'(popOk);
      if (strb.dropEvt) lostCount <= lostCount + 1'b1;
      recValid <= strb.writeRec;
      if (strb.writeRec) recData <= newRec;
    end
  end

  assign headValid = (bankUsed != '0);
  assign headCount = bankCnt[head];
  assign headTrunc = bankTrunc[head];
  assign rdData    = bankWord[head];

  // R5: occupancy stays within the bank count
  a_r5_used_bound: assert property (@(posedge clk) disable iff (!rstN)
    bankUsed <= USED_W'(NBANKS));

  // R7: each dropped event advances the lost counter by one
  a_r7_lost_step: assert property (@(posedge clk) disable iff (!rstN)
    strb.dropEvt |=> lostCount == $past(lostCount) + {{(LOST_W-1){1'b0}}, 1'b1});

  // R8: a pop on an occupied buffer without a close frees one bank
  a_r8_pop_frees: assert property (@(posedge clk) disable iff (!rstN)
    (popBank && bankUsed != '0 && !strb.closeEvt) |=> bankUsed == $past(bankUsed) - 1'b1);

  // R1: padding bits of a streamed record are zero
  a_r1_pad_zero: assert property (@(posedge clk) disable iff (!rstN)
    recValid |-> recData[WORD_W +: PAD_W] == '0);
endmodule

// File: rtl/chain_suppressor.sv
module chain_suppressor
  import cs_pkg::*;
#(
  parameter int CARDS  = 16,
  parameter int NBANKS = 6,
  parameter int DEPTH  = 4,
  parameter int LOST_W = 8,
  localparam int IDX_W  = $clog2(CARDS),
  localparam int SLOT_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int USED_W = $clog2(NBANKS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serIn,
  input  logic              serValid,
  input  logic              evtStart,
  input  logic              testMode,
  input  logic [ADDR_W-1:0] chainBase,
  input  logic              popBank,
  input  logic [SLOT_W-1:0] rdWord,
  output logic              recValid,
  output logic [REC_W-1:0]  recData,
  output logic              headValid,
  output logic [CNT_W-1:0]  headCount,
  output logic              headTrunc,
  output logic [REC_W-1:0]  rdData,
  output logic [USED_W-1:0] bankUsed,
  output logic [LOST_W-1:0] lostCount
);
  logic              wordValid;
  logic [WORD_W-1:0] wordData;
  logic [IDX_W-1:0]  wordIdx;
  logic              lastWord;
  ctrlStrobes_t      strb;

  cs_deser #(.CARDS(CARDS)) u_deser (
    .clk(clk), .rstN(rstN), .serIn(serIn), .serValid(serValid),
    .evtStart(evtStart), .wordValid(wordValid), .wordData(wordData),
    .wordIdx(wordIdx), .lastWord(lastWord)
  );

  cs_ctrl #(.NBANKS(NBANKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .serValid(serValid), .evtStart(evtStart),
    .testMode(testMode), .wordValid(wordValid), .wordData(wordData),
    .lastWord(lastWord), .bankUsed(bankUsed), .strb(strb)
  );

  cs_bank_store #(.CARDS(CARDS), .NBANKS(NBANKS), .DEPTH(DEPTH), .LOST_W(LOST_W)) u_store (
    .clk(clk), .rstN(rstN), .strb(strb), .wordData(wordData), .wordIdx(wordIdx),
    .chainBase(chainBase), .popBank(popBank), .rdWord(rdWord),
    .recValid(recValid), .recData(recData), .headValid(headValid),
    .headCount(headCount), .headTrunc(headTrunc), .rdData(rdData),
    .bankUsed(bankUsed), .lostCount(lostCount)
  );
endmodule

// File: tb/sim_chain_suppressor.sv
module sim_chain_suppressor;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        serIn = 1'b0, serValid = 1'b0, evtStart = 1'b0, testMode = 1'b0;
  logic [9:0]  chainBase = 10'd0;
  logic        popBank = 1'b0;
  logic [1:0]  rdWord = 2'd0;
  logic        recValid, headValid, headTrunc;
  logic [31:0] recData, rdData;
  logic [2:0]  headCount, bankUsed;
  logic [7:0]  lostCount;

  int errors = 0, checks = 0;
  bit finished = 0;
  logic [31:0] cap [32];
  int capN = 0;

  always #10 clk = ~clk;

  chain_suppressor u0 (
    .clk(clk), .rstN(rstN), .serIn(serIn), .serValid(serValid), .evtStart(evtStart),
    .testMode(testMode), .chainBase(chainBase), .popBank(popBank), .rdWord(rdWord),
    .recValid(recValid), .recData(recData), .headValid(headValid), .headCount(headCount),
    .headTrunc(headTrunc), .rdData(rdData), .bankUsed(bankUsed), .lostCount(lostCount)
  );

  always @(negedge clk) if (recValid && capN < 32) begin
    cap[capN] = recData;
    capN++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic sendEvent(input logic [255:0] ev);
    capN = 0;
    for (int k = 0; k < 16; k++)
      for (int j = 15; j >= 0; j--) begin
        @(negedge clk);
        serValid = 1'b1;
        serIn    = ev[16*k + j];
        evtStart = (k == 0 && j == 15);
      end
    @(negedge clk);
    serValid = 1'b0; evtStart = 1'b0; serIn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic doPop();
    @(negedge clk); popBank = 1'b1;
    @(negedge clk); popBank = 1'b0;
    #1;
  endtask

  // Checks stream then the head bank against the record rules, then pops it.
  task automatic checkEvent(input logic [255:0] ev, input bit tm, input string req);
    logic [31:0] expRec [16];
    int n = 0;
    for (int k = 0; k < 16; k++)
      if (tm || ev[16*k +: 16] != 16'h0) begin
        expRec[n] = {chainBase + 10'(k), 6'b0, ev[16*k +: 16]};
        n++;
      end
    chk(capN == n, req, "stream record count", capN, n);
    for (int i = 0; i < n && i < capN; i++)
      chk(cap[i] == expRec[i], req, "stream record", cap[i], expRec[i]);
    chk(headValid == 1'b1, req, "head valid", headValid, 1);
    chk(headCount == 3'((n > 4) ? 4 : n), req, "head count", headCount, (n > 4) ? 4 : n);
    chk(headTrunc == (n > 4), req, "truncation flag", headTrunc, n > 4);
    for (int i = 0; i < n && i < 4; i++) begin
      @(negedge clk); rdWord = 2'(i); #1;
      chk(rdData == expRec[i], req, "stored record", rdData, expRec[i]);
    end
    doPop();
  endtask

  task automatic tResetState();
    chk(bankUsed == 0, "R9", "bankUsed after reset", bankUsed, 0);
    chk(headValid == 0, "R9", "headValid after reset", headValid, 0);
    chk(recValid == 0, "R9", "recValid after reset", recValid, 0);
    chk(lostCount == 0, "R9", "lostCount after reset", lostCount, 0);
  endtask

  task automatic tSparse();  // R1 R2 R3 R5
    logic [255:0] ev = '0;
    ev[0 +: 16]   = 16'h8001;
    ev[112 +: 16] = 16'h0040;
    ev[240 +: 16] = 16'hFFFF;
    chainBase = 10'd100; testMode = 1'b0;
    sendEvent(ev);
    chk(bankUsed == 1, "R5", "one bank per event", bankUsed, 1);
    checkEvent(ev, 1'b0, "R3");
  endtask

  task automatic tEmpty();  // R5: empty event still takes a bank
    sendEvent('0);
    chk(bankUsed == 1, "R5", "empty event bank", bankUsed, 1);
    checkEvent('0, 1'b0, "R5");
    chk(bankUsed == 0, "R8", "bank freed by pop", bankUsed, 0);
  endtask

  task automatic tTruncate();  // R6
    logic [255:0] ev = '0;
    for (int k = 1; k < 13; k += 2) ev[16*k +: 16] = 16'(k * 16'h0111);
    chainBase = 10'd500;
    sendEvent(ev);
    checkEvent(ev, 1'b0, "R6");
  endtask

  task automatic tTestMode();  // R4, address wrap of R2
    logic [255:0] ev = '0;
    ev[32 +: 16] = 16'h1234;
    chainBase = 10'd1020; testMode = 1'b1;
    sendEvent(ev);
    checkEvent(ev, 1'b1, "R4");
    testMode = 1'b0;
  endtask

  task automatic tStray();  // R10
    capN = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); serValid = 1'b1; serIn = 1'b1; evtStart = 1'b0;
    end
    @(negedge clk); serValid = 1'b0;
    repeat (4) @(negedge clk);
    chk(capN == 0, "R10", "records from stray bits", capN, 0);
    chk(bankUsed == 0, "R10", "banks after stray bits", bankUsed, 0);
  endtask

  task automatic tFullAndOrder();  // R7 R8 R5
    logic [255:0] ev;
    chainBase = 10'd0;
    for (int i = 0; i < 6; i++) begin
      ev = '0; ev[0 +: 16] = 16'(i + 1);
      sendEvent(ev);
    end
    chk(bankUsed == 6, "R7", "all banks occupied", bankUsed, 6);
    ev = '0; ev[0 +: 16] = 16'h00FF;
    sendEvent(ev);
    chk(capN == 0, "R7", "records from dropped event", capN, 0);
    chk(lostCount == 1, "R7", "lost counter", lostCount, 1);
    chk(bankUsed == 6, "R7", "occupancy after drop", bankUsed, 6);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); rdWord = 2'd0; #1;
      chk(rdData == {10'd0, 6'b0, 16'(i + 1)}, "R8", "oldest bank first", rdData, {10'd0, 6'b0, 16'(i + 1)});
      doPop();
    end
    chk(bankUsed == 0, "R8", "all banks released", bankUsed, 0);
    doPop();
    chk(bankUsed == 0, "R8", "pop on empty ignored", bankUsed, 0);
    chk(headValid == 0, "R8", "head empty after pops", headValid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    tResetState();
    tSparse();
    tEmpty();
    tTruncate();
    tTestMode();
    tStray();
    tFullAndOrder();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule